// File: doc/BRIEF.md
# PS/2 Device-Side Frame Transmitter

This block sends single bytes from a pointing device to its host over the two-wire PS/2 bus. The device owns the bus clock. Each line is handled as an open-drain pair: an output enable that pulls the line low, plus a raw input that reads back the resolved line level through a two-flop synchroniser. A byte arrives over a valid/ready handshake. It is then serialised as an 11-bit frame, with each clock half-period timed by a tick counter derived from the system clock (about 12.5 kHz by default).

A frame starts only after the bus is seen idle, which means both lines are high. While the clock is released, the block watches the clock line for a low level forced by the host. If the host interrupts before the tenth clock's rising edge, the block lets go of both lines, pulses `txAbort` and keeps the byte. It then resends the byte as soon as the bus is idle again, and accepts no new byte before that. If the host interrupts later than that, the frame still counts as delivered. A completed frame pulses `txDone` and frees the buffer.

Top module: `ps2_dev_tx`

## Requirements
- R1: Each frame gives exactly 11 falling clock edges. The data line level sampled at these edges is, in order: 0, then data bits 0 through 7, then the odd parity bit (the complement of the XOR of the eight data bits), then 1.
- R2: While the clock line reads low, no frame starts. Both output enables stay deasserted, even with a byte waiting.
- R3: While the clock line reads high and the data line reads low (the host asking to send), no frame starts. Both output enables stay deasserted.
- R4: The data output enable changes only while the clock line is released. It stays constant through every clock-low phase.
- R5: Every clock-low phase driven by the block lasts exactly CLK_HZ/(2*BIT_HZ) system clock cycles.
- R6: A host-forced clock low seen during the released phase of any of the first ten frame bits (start, data and parity) ends the frame. Both enables are released, `txAbort` pulses for one cycle, and the byte stays buffered, so `txReady` stays low.
- R7: An aborted byte is sent again, in full and unchanged, once the bus is next idle. No new byte is accepted until that resend completes.
- R8: A host-forced clock low seen during the released phase of the stop bit ends the frame as delivered. `txDone` pulses, `txAbort` does not, and the byte is not sent again.
- R9: After the eleventh clock-low phase ends, `txDone` pulses for exactly one cycle and `txReady` is high in that same cycle.
- R10: During and right after reset, both enables are deasserted, `txReady` is high, and `txDone` and `txAbort` are low.
- R11: A byte is taken when `txValid` and `txReady` are both high on a clock edge. `txReady` stays low while that byte is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | `txData` is valid |
| txReady | output | 1 | Block can take a byte |
| clkIn | input | 1 | Resolved level of the bus clock line |
| dataIn | input | 1 | Resolved level of the bus data line |
| clkOe | output | 1 | Pull the bus clock line low |
| dataOe | output | 1 | Pull the bus data line low |
| txDone | output | 1 | One-cycle pulse: frame delivered |
| txAbort | output | 1 | One-cycle pulse: frame cut short, byte kept |

## Verification
The assertions assume that `clkIn` and `dataIn` are the wired-AND of the block's own enables and the host's pulls. They also assume the half-period is at least twice the synchroniser delay plus one, so that a contention check can land inside each released phase. The bench models both lines as exactly that resolution with a five-cycle half-period. It raises host pulls only at points aligned to the observed bus clock: at the start of a chosen bit's released phase, or while the bus is idle. This makes each interrupt fall clearly before or after the tenth rising edge. `txValid` is only held while `txReady` is low, and never against a frame already running.

// File: rtl/ps2_tx_pkg.sv
package ps2_tx_pkg;

  localparam int FRAME_BITS  = 11;
  localparam int STOP_IDX    = FRAME_BITS - 1;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  localparam int SYNC_STAGES = 2;
  localparam int GUARD_TICKS = SYNC_STAGES + 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } txState_t;

  typedef struct packed {
    logic accept;
    logic startFrame;
    logic putBit;
    logic pullClk;
    logic freeClk;
    logic releaseAll;
    logic dropByte;
  } txStrobe_t;

  typedef struct packed {
    logic busIdle;
    logic hostClkLow;
    logic tickMid;
    logic tickEnd;
    logic guardOk;
    logic lastBit;
    logic bufFull;
  } txStatus_t;

endpackage

// File: rtl/ps2_tx_datapath.sv
module ps2_tx_datapath
  import ps2_tx_pkg::*;
#(
  parameter int HALF_TICKS = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] txData,
  input  logic       clkIn,
  input  logic       dataIn,
  input  txStrobe_t  strobe,
  output txStatus_t  status,
  output logic       clkOe,
  output logic       dataOe
);

  localparam int CNT_W = $clog2(HALF_TICKS + 1);
  localparam logic [CNT_W-1:0] TICK_LAST  = CNT_W'(HALF_TICKS - 1);
  localparam logic [CNT_W-1:0] TICK_MID   = CNT_W'(HALF_TICKS / 2);
  localparam logic [CNT_W-1:0] TICK_GUARD = CNT_W'(GUARD_TICKS);
  localparam logic [IDX_W-1:0] IDX_STOP   = IDX_W'(STOP_IDX);
  localparam logic [IDX_W-1:0] IDX_PARITY = IDX_W'(STOP_IDX - 1);

  logic [SYNC_STAGES-1:0] clkSyncQ;
  logic [SYNC_STAGES-1:0] dataSyncQ;
  logic [CNT_W-1:0]       tickCnt;
  logic [IDX_W-1:0]       bitIdx;
  logic [7:0]             bufByte;
  logic                   bufFull;
  logic                   bitVal;
  logic                   clkSeen;
  logic                   dataSeen;

  // input synchronisers, reset to the released (high) level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSyncQ  <= '1;
      dataSyncQ <= '1;
    end else begin
      clkSyncQ  <= {clkSyncQ[SYNC_STAGES-2:0], clkIn};
      dataSyncQ <= {dataSyncQ[SYNC_STAGES-2:0], dataIn};
    end
  end

  assign clkSeen  = clkSyncQ[SYNC_STAGES-1];
  assign dataSeen = dataSyncQ[SYNC_STAGES-1];

  // half-period tick counter, saturating at the last tick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobe.startFrame || strobe.pullClk || strobe.freeClk || strobe.releaseAll) begin
      tickCnt <= '0;
    end else if (tickCnt != TICK_LAST) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  // frame bit position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx <= '0;
    end else if (strobe.startFrame) begin
      bitIdx <= '0;
    end else if (strobe.freeClk && bitIdx != IDX_STOP) begin
      bitIdx <= bitIdx + 1'b1;
    end
  end

  // byte buffer kept across aborted attempts
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufByte <= '0;
      bufFull <= 1'b0;
    end else if (strobe.accept) begin
      bufByte <= txData;
      bufFull <= 1'b1;
    end else if (strobe.dropByte) begin
      bufFull <= 1'b0;
    end
  end

  // level of the current frame bit
  always_comb begin
    if (bitIdx == '0) begin
      bitVal = 1'b0;
    end else if (bitIdx == IDX_PARITY) begin
      bitVal = ~^bufByte;
    end else if (bitIdx == IDX_STOP) begin
      bitVal = 1'b1;
    end else begin
      bitVal = bufByte[3'(bitIdx - 1'b1)];
    end
  end

  // open-drain enables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkOe  <= 1'b0;
      dataOe <= 1'b0;
    end else begin
      if (strobe.pullClk) begin
        clkOe <= 1'b1;
      end else if (strobe.freeClk || strobe.releaseAll) begin
        clkOe <= 1'b0;
      end
      if (strobe.startFrame || strobe.releaseAll) begin
        dataOe <= 1'b0;
      end else if (strobe.putBit) begin
        dataOe <= ~bitVal;
      end
    end
  end

  assign status.busIdle    = clkSeen && dataSeen;
  assign status.hostClkLow = !clkSeen;
  assign status.tickMid    = (tickCnt == TICK_MID);
  assign status.tickEnd    = (tickCnt == TICK_LAST);
  assign status.guardOk    = (tickCnt >= TICK_GUARD);
  assign status.lastBit    = (bitIdx == IDX_STOP);
  assign status.bufFull    = bufFull;

  // R11: a byte is only loaded into an empty buffer
  assert_load_empty_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |-> !bufFull);

  // R2 and R3: a frame begins only when both synchronised lines are high
  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startFrame |-> (clkSeen && dataSeen));

  // R4: the data enable never moves while the clock is held low
  assert_data_steady_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOe) |-> (!clkOe && !$past(clkOe)));

  // R1: the bit position never runs past the stop bit
  assert_bit_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= IDX_STOP);

  // R5: the clock is pulled low only from the released level
  assert_clock_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkOe) |-> $past(status.tickEnd));

endmodule

// File: rtl/ps2_tx_ctrl.sv
module ps2_tx_ctrl
  import ps2_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txValid,
  input  txStatus_t status,
  output txStrobe_t strobe,
  output logic      txReady,
  output logic      txDone,
  output logic      txAbort
);

  txState_t state;
  txState_t nextState;
  logic     doneSet;
  logic     abortSet;

  always_comb begin
    nextState = state;
    strobe    = '0;
    doneSet   = 1'b0;
    abortSet  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (status.bufFull) begin
          if (status.busIdle) begin
            strobe.startFrame = 1'b1;
            nextState         = ST_HIGH;
          end
        end else if (txValid) begin
          strobe.accept = 1'b1;
        end
      end
      ST_HIGH: begin
        if (status.guardOk && status.hostClkLow) begin
          strobe.releaseAll = 1'b1;
          nextState         = ST_IDLE;
          if (status.lastBit) begin
            strobe.dropByte = 1'b1;
            doneSet         = 1'b1;
          end else begin
            abortSet = 1'b1;
          end
        end else if (status.tickMid) begin
          strobe.putBit = 1'b1;
        end else if (status.tickEnd) begin
          strobe.pullClk = 1'b1;
          nextState      = ST_LOW;
        end
      end
      ST_LOW: begin
        if (status.tickEnd) begin
          strobe.freeClk = 1'b1;
          if (status.lastBit) begin
            strobe.releaseAll = 1'b1;
            strobe.dropByte   = 1'b1;
            doneSet           = 1'b1;
            nextState         = ST_IDLE;
          end else begin
            nextState = ST_HIGH;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      txDone  <= 1'b0;
      txAbort <= 1'b0;
    end else begin
      state   <= nextState;
      txDone  <= doneSet;
      txAbort <= abortSet;
    end
  end

  assign txReady = (state == ST_IDLE) && !status.bufFull;

  // R9: a frame ends in exactly one way
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(txDone && txAbort));

  // R6: an aborted frame leaves its byte buffered
  assert_abort_keeps_R6: assert property (@(posedge clk) disable iff (!rstN)
    txAbort |-> status.bufFull);

  // R8: a delivered frame frees the buffer
  assert_done_drops_R8: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> !status.bufFull);

  // R7: right after an abort no new byte can be taken
  assert_retry_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    txAbort |=> !txReady);

endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx
  import ps2_tx_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BIT_HZ = 12_500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady,
  input  logic       clkIn,
  input  logic       dataIn,
  output logic       clkOe,
  output logic       dataOe,
  output logic       txDone,
  output logic       txAbort
);

  localparam int HALF_TICKS = CLK_HZ / (2 * BIT_HZ);

  txStrobe_t strobe;
  txStatus_t status;

  ps2_tx_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .txValid (txValid),
    .status  (status),
    .strobe  (strobe),
    .txReady (txReady),
    .txDone  (txDone),
    .txAbort (txAbort)
  );

  ps2_tx_datapath #(
    .HALF_TICKS (HALF_TICKS)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .txData (txData),
    .clkIn  (clkIn),
    .dataIn (dataIn),
    .strobe (strobe),
    .status (status),
    .clkOe  (clkOe),
    .dataOe (dataOe)
  );

endmodule

// File: tb/ps2_dev_tx_test.sv
`timescale 1ns/1ps
module ps2_dev_tx_test;

  localparam int CLK_HZ = 1000;
  localparam int BIT_HZ = 100;
  localparam int HALF   = CLK_HZ / (2 * BIT_HZ);

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txReady;
  logic       clkOe;
  logic       dataOe;
  logic       txDone;
  logic       txAbort;
  logic       hostClkLow = 1'b0;
  logic       hostDataLow = 1'b0;
  logic       clkLine;
  logic       dataLine;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // bus monitor state
  int          fallCnt = 0;
  logic [10:0] rec = '0;
  logic        lowData = 1'b1;
  logic        prevClk = 1'b1;
  int          dataGlitch = 0;
  int          widthErr = 0;
  int          lowRun = 0;
  int          busyCnt = 0;

  assign clkLine  = !(clkOe || hostClkLow);
  assign dataLine = !(dataOe || hostDataLow);

  always #2 clk = ~clk;

  ps2_dev_tx #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ)) uut (
    .clk     (clk),
    .rstN    (rstN),
    .txData  (txData),
    .txValid (txValid),
    .txReady (txReady),
    .clkIn   (clkLine),
    .dataIn  (dataLine),
    .clkOe   (clkOe),
    .dataOe  (dataOe),
    .txDone  (txDone),
    .txAbort (txAbort)
  );

  always @(negedge clk) begin
    if (prevClk && !clkLine && clkOe) begin
      if (fallCnt < 11) rec[fallCnt] = dataLine;
      fallCnt = fallCnt + 1;
      lowData = dataLine;
    end
    if (!clkLine && clkOe && dataLine != lowData) dataGlitch = dataGlitch + 1;
    if (clkOe) begin
      lowRun = lowRun + 1;
    end else begin
      if (lowRun != 0 && lowRun != HALF) widthErr = widthErr + 1;
      lowRun = 0;
    end
    if (clkOe || dataOe) busyCnt = busyCnt + 1;
    prevClk = clkLine;
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 190000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog actual=%0d expected<=190000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearMon();
    fallCnt    = 0;
    rec        = '0;
    dataGlitch = 0;
    busyCnt    = 0;
  endtask

  function automatic logic [10:0] expFrame(input logic [7:0] b);
    return {1'b1, ~^b, b, 1'b0};
  endfunction

  task automatic pushByte(input logic [7:0] b);
    tick();
    while (!txReady) tick();
    txData  = b;
    txValid = 1'b1;
    tick();
    txValid = 1'b0;
  endtask

  task automatic waitOutcome(output bit gotDone, output bit gotAbort, input int limit);
    gotDone  = 1'b0;
    gotAbort = 1'b0;
    for (int i = 0; i < limit; i++) begin
      if (txDone || txAbort) begin
        gotDone  = txDone;
        gotAbort = txAbort;
        break;
      end
      tick();
    end
  endtask

  task automatic fullFrame(input logic [7:0] b, input string req);
    bit d;
    bit a;
    waitOutcome(d, a, 400);
    check(d && !a, req, {d, a}, 2'b10);
    check(fallCnt == 11 && rec == expFrame(b), req, {fallCnt[3:0], rec}, {4'd11, expFrame(b)});
  endtask

  task automatic abortAt(input logic [7:0] b, input int k);
    bit d;
    bit a;
    bit stillBlocked;
    clearMon();
    pushByte(b);
    for (int i = 0; i < 400; i++) begin
      if (fallCnt == k && !clkOe && (k > 0 || dataOe)) break;
      tick();
    end
    hostClkLow = 1'b1;
    waitOutcome(d, a, 60);
    check(a && !d, "R6 abort pulse", {d, a}, 2'b01);
    check(!clkOe && !dataOe && !txReady, "R6 lines freed, byte kept",
          {clkOe, dataOe, txReady}, 3'b000);
    busyCnt = 0;
    txData  = 8'hFF;
    txValid = 1'b1;
    stillBlocked = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (txReady) stillBlocked = 1'b0;
    end
    txValid = 1'b0;
    check(stillBlocked && busyCnt == 0, "R7 no new byte, no start while held",
          {stillBlocked, busyCnt[7:0]}, 9'h100);
    clearMon();
    hostClkLow = 1'b0;
    fullFrame(b, "R7 retained byte resent");
  endtask

  initial begin
    bit d;
    bit a;
    // reset
    for (int i = 0; i < 5; i++) tick();
    check(!clkOe && !dataOe && txReady && !txDone && !txAbort, "R10 in reset",
          {clkOe, dataOe, txReady, txDone, txAbort}, 5'b00100);
    rstN = 1'b1;
    tick();
    check(!clkOe && !dataOe && txReady && !txDone && !txAbort, "R10 after reset",
          {clkOe, dataOe, txReady, txDone, txAbort}, 5'b00100);

    // exhaustive byte sweep: R1 frame content, R9 done pulse
    widthErr = 0;
    for (int v = 0; v < 256; v++) begin
      clearMon();
      pushByte(8'(v));
      if (v == 8'h3C) check(!txReady, "R11 ready low while held", txReady, 0);
      waitOutcome(d, a, 400);
      check(d && !a && fallCnt == 11 && rec == expFrame(8'(v)), "R1 frame bits",
            {d, a, fallCnt[3:0], rec}, {2'b10, 4'd11, expFrame(8'(v))});
      if (v == 8'h81) begin
        check(txReady, "R9 ready with done", txReady, 1);
        tick();
        check(!txDone, "R9 done lasts one cycle", txDone, 0);
      end
      check(dataGlitch == 0, "R4 data stable in clock low", dataGlitch, 0);
    end
    check(widthErr == 0, "R5 clock low width", widthErr, 0);

    // R2: clock inhibited by host
    hostClkLow = 1'b1;
    clearMon();
    pushByte(8'h5A);
    for (int i = 0; i < 60; i++) tick();
    check(busyCnt == 0, "R2 no start while clock low", busyCnt, 0);
    clearMon();
    hostClkLow = 1'b0;
    fullFrame(8'h5A, "R2 start after inhibit");

    // R3: host request-to-send
    hostDataLow = 1'b1;
    clearMon();
    pushByte(8'hC3);
    for (int i = 0; i < 60; i++) tick();
    check(busyCnt == 0, "R3 no start while data low", busyCnt, 0);
    clearMon();
    hostDataLow = 1'b0;
    fullFrame(8'hC3, "R3 start after request");

    // R6 and R7: contention before the tenth rising edge
    abortAt(8'hA5, 0);
    abortAt(8'h01, 1);
    abortAt(8'h7E, 5);
    abortAt(8'hB2, 9);

    // R8: contention in the stop bit's released phase
    clearMon();
    pushByte(8'h96);
    for (int i = 0; i < 400; i++) begin
      if (fallCnt == 10 && !clkOe) break;
      tick();
    end
    hostClkLow = 1'b1;
    waitOutcome(d, a, 60);
    check(d && !a, "R8 late contention delivers", {d, a}, 2'b10);
    check(txReady, "R8 byte dropped", txReady, 1);
    for (int i = 0; i < 10; i++) tick();
    hostClkLow = 1'b0;
    busyCnt = 0;
    for (int i = 0; i < 60; i++) tick();
    check(busyCnt == 0, "R8 no resend", busyCnt, 0);

    check(widthErr == 0, "R5 clock low width overall", widthErr, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule